// File: doc/BRIEF.md
# BERT Receiver Status and Sticky Event Register

This block keeps the receive-side status of a bit error rate tester in one small register pair. A live word shows, as they stand now, the synchronization state of the receive pattern, whether the error count is nonzero, and whether a counter update has finished. A second word holds sticky event bits that record that something happened. A bit is set by its own rule: a rising edge, a change in either direction, or a direct event strobe. Software clears a sticky bit by writing 1 to it.

The update-complete flag follows a request/complete handshake. A mode input picks the request that counts, either a local one or a global one. The flag goes high once the update-complete strobe arrives while that request is high, and it drops whenever the request goes low. Pattern generation, sync search and the counters themselves are outside the block and reach it only as input signals. Host access uses a plain synchronous write strobe, a word select and a combinational read mux.

Top module: `bert_status_regs`

## Requirements
- R1: Live word layout: bit 3 is the update-complete flag, bit 1 the nonzero-count flag and bit 0 the out-of-sync flag. Bit 2 always reads 0.
- R2: With the active update request high, an update-complete strobe sampled at a clock edge sets live bit 3 at that edge.
- R3: Live bit 3 is 0 after any edge at which the active request was low. The active request is pmu_local_i when pmu_mode_i is 0 and pmu_global_i when pmu_mode_i is 1.
- R4: Live bit 1 is set at an edge where cnt_nz_i is 1 and stays set until an edge at which the active request has just risen. That edge clears it, and the clear wins over cnt_nz_i.
- R5: Live bit 0 equals oos_i sampled at the previous edge.
- R6: Sticky bit 3 is set one edge after live bit 3 goes from 0 to 1.
- R7: Sticky bit 2 is set at the edge where bit_err_i is sampled high.
- R8: Sticky bit 1 is set one edge after live bit 1 goes from 0 to 1.
- R9: Sticky bit 0 is set one edge after live bit 0 changes, in either direction.
- R10: A sticky bit stays set until an edge with wr_en_i=1, sel_i=1 and a 1 in that position of wr_data_i. Writing 0 bits, or writing with sel_i=0, changes nothing. When a set event and a clear fall on the same edge, the set wins.
- R11: After reset the live word is 4'b0001 and the sticky word is 4'b0000.
- R12: rd_data_o shows the sticky word when sel_i=1 and the live word when sel_i=0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oos_i | input | 1 | Receive pattern out of sync |
| bit_err_i | input | 1 | Single bit error strobe |
| cnt_nz_i | input | 1 | Error count is one or more |
| pmu_mode_i | input | 1 | 0 selects local request, 1 selects global request |
| pmu_local_i | input | 1 | Local counter update request |
| pmu_global_i | input | 1 | Global or port counter update request |
| pmu_done_i | input | 1 | Counter update finished strobe |
| wr_en_i | input | 1 | Host write strobe |
| sel_i | input | 1 | Word select: 0 live, 1 sticky |
| wr_data_i | input | 4 | Write data, 1 clears a sticky bit |
| status_o | output | 4 | Live status word |
| latched_o | output | 4 | Sticky event word |
| rd_data_o | output | 4 | Read data of the selected word |

## Verification
Live flags and the bit-error sticky bit are due at the first edge after their input is sampled. The edge-derived sticky bits (3, 1, 0) are due one edge later, because they compare the live flag with its registered copy. The read mux follows sel_i in the same cycle. The driver drives inputs at the falling edge and pushes the expected post-edge words into a queue. The monitor pops and compares them a quarter period after each rising edge, so every result is sampled after exactly the edges it needs.

// File: rtl/bert_stat_pkg.sv
package bert_stat_pkg;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned B_UPD  = 3;
  localparam int unsigned B_ERR  = 2;
  localparam int unsigned B_NZ   = 1;
  localparam int unsigned B_OOS  = 0;
endpackage

// File: rtl/bert_live_flags.sv
module bert_live_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oos_i,
  input  logic cnt_nz_i,
  input  logic pmu_mode_i,
  input  logic pmu_local_i,
  input  logic pmu_global_i,
  input  logic pmu_done_i,
  output logic upd_o,
  output logic nz_o,
  output logic oos_o
);
  logic req_act, req_q, req_rise;

  assign req_act  = pmu_mode_i ? pmu_global_i : pmu_local_i;
  assign req_rise = req_act & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      upd_o <= 1'b0;
      nz_o  <= 1'b0;
      oos_o <= 1'b1;
    end else begin
      req_q <= req_act;
      oos_o <= oos_i;
      if (!req_act)        upd_o <= 1'b0;
      else if (pmu_done_i) upd_o <= 1'b1;
      // counter update clears the nonzero flag, ahead of a new count
      if (req_rise)      nz_o <= 1'b0;
      else if (cnt_nz_i) nz_o <= 1'b1;
    end
  end
endmodule

// File: rtl/bert_edge_events.sv
module bert_edge_events (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic       nz_i,
  input  logic       oos_i,
  input  logic       bit_err_i,
  output logic [3:0] ev_o
);
  import bert_stat_pkg::*;
  logic upd_q, nz_q, oos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      nz_q  <= 1'b0;
      oos_q <= 1'b1;
    end else begin
      upd_q <= upd_i;
      nz_q  <= nz_i;
      oos_q <= oos_i;
    end
  end

  always_comb begin
    ev_o        = '0;
    ev_o[B_UPD] = upd_i & ~upd_q;
    ev_o[B_ERR] = bit_err_i;
    ev_o[B_NZ]  = nz_i & ~nz_q;
    ev_o[B_OOS] = oos_i ^ oos_q;
  end
endmodule

// File: rtl/bert_sticky_bank.sv
module bert_sticky_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/bert_status_regs.sv
module bert_status_regs
  import bert_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oos_i,
  input  logic              bit_err_i,
  input  logic              cnt_nz_i,
  input  logic              pmu_mode_i,
  input  logic              pmu_local_i,
  input  logic              pmu_global_i,
  input  logic              pmu_done_i,
  input  logic              wr_en_i,
  input  logic              sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] latched_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic upd, nz, oos;
  logic [WORD_W-1:0] ev, clr;

  bert_live_flags i_live (
    .clk_i, .rst_ni, .oos_i, .cnt_nz_i, .pmu_mode_i, .pmu_local_i,
    .pmu_global_i, .pmu_done_i, .upd_o(upd), .nz_o(nz), .oos_o(oos)
  );

  bert_edge_events i_ev (
    .clk_i, .rst_ni, .upd_i(upd), .nz_i(nz), .oos_i(oos),
    .bit_err_i, .ev_o(ev)
  );

  assign clr = (wr_en_i && sel_i) ? wr_data_i : '0;

  bert_sticky_bank #(.W(WORD_W)) i_sticky (
    .clk_i, .rst_ni, .set_i(ev), .clr_i(clr), .q_o(latched_o)
  );

  always_comb begin
    status_o        = '0;
    status_o[B_UPD] = upd;
    status_o[B_NZ]  = nz;
    status_o[B_OOS] = oos;
  end

  assign rd_data_o = sel_i ? latched_o : status_o;
endmodule

// File: rtl/bert_status_chk.sv
module bert_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oos_i,
  input logic       bit_err_i,
  input logic       cnt_nz_i,
  input logic       pmu_mode_i,
  input logic       pmu_local_i,
  input logic       pmu_global_i,
  input logic       pmu_done_i,
  input logic       wr_en_i,
  input logic       sel_i,
  input logic [3:0] wr_data_i,
  input logic [3:0] status_o,
  input logic [3:0] latched_o,
  input logic [3:0] rd_data_o
);
  logic req;
  logic [3:0] keep;
  assign req  = pmu_mode_i ? pmu_global_i : pmu_local_i;
  assign keep = latched_o & ~((wr_en_i && sel_i) ? wr_data_i : 4'b0);

  p_bit2_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] == 1'b0);
  p_upd_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && pmu_done_i |=> status_o[3]);
  p_upd_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> !status_o[3]);
  p_nz_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_nz_i && !req |=> status_o[1]);
  p_oos_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[0] == $past(oos_i));
  p_err_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_err_i |=> latched_o[2]);
  p_oos_latch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] != $past(status_o[0]) |=> latched_o[0]);
  p_sticky_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (latched_o & $past(keep)) == $past(keep));
  p_rd_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> rd_data_o == latched_o);
endmodule

bind bert_status_regs bert_status_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .oos_i(oos_i), .bit_err_i(bit_err_i),
  .cnt_nz_i(cnt_nz_i), .pmu_mode_i(pmu_mode_i), .pmu_local_i(pmu_local_i),
  .pmu_global_i(pmu_global_i), .pmu_done_i(pmu_done_i), .wr_en_i(wr_en_i),
  .sel_i(sel_i), .wr_data_i(wr_data_i), .status_o(status_o),
  .latched_o(latched_o), .rd_data_o(rd_data_o)
);

// File: tb/test_bert_status_regs.sv
module test_bert_status_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic oos_i = 1'b1, bit_err_i = 1'b0, cnt_nz_i = 1'b0, pmu_mode_i = 1'b0;
  logic pmu_local_i = 1'b0, pmu_global_i = 1'b0, pmu_done_i = 1'b0;
  logic wr_en_i = 1'b0, sel_i = 1'b0;
  logic [3:0] wr_data_i = 4'h0;
  logic [3:0] status_o, latched_o, rd_data_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bert_status_regs i_bert_status_regs (
    .clk_i(clk), .rst_ni, .oos_i, .bit_err_i, .cnt_nz_i, .pmu_mode_i,
    .pmu_local_i, .pmu_global_i, .pmu_done_i, .wr_en_i, .sel_i, .wr_data_i,
    .status_o, .latched_o, .rd_data_o
  );

  // reference model state
  logic m_upd = 0, m_nz = 0, m_oos = 1, m_req_q = 0;
  logic m_upd_p = 0, m_nz_p = 0, m_oos_p = 1;
  logic [3:0] m_lat = 4'h0;

  logic [11:0] q_exp[$];
  string       q_tag[$];

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic oos, logic err, logic cnt, logic mode, logic loc,
                      logic glob, logic done, logic wr, logic sel,
                      logic [3:0] wd, string tag);
    logic req;
    logic [3:0] ev, clr, st;
    @(negedge clk);
    oos_i = oos; bit_err_i = err; cnt_nz_i = cnt; pmu_mode_i = mode;
    pmu_local_i = loc; pmu_global_i = glob; pmu_done_i = done;
    wr_en_i = wr; sel_i = sel; wr_data_i = wd;
    req = mode ? glob : loc;
    ev  = {m_upd & ~m_upd_p, err, m_nz & ~m_nz_p, m_oos ^ m_oos_p};
    clr = (wr && sel) ? wd : 4'h0;
    m_lat   = (m_lat & ~clr) | ev;
    m_upd_p = m_upd; m_nz_p = m_nz; m_oos_p = m_oos;
    m_upd   = !req ? 1'b0 : (done ? 1'b1 : m_upd);
    m_nz    = (req && !m_req_q) ? 1'b0 : (cnt ? 1'b1 : m_nz);
    m_oos   = oos;
    m_req_q = req;
    st = {m_upd, 1'b0, m_nz, m_oos};
    q_exp.push_back({st, m_lat, sel ? m_lat : st});
    q_tag.push_back(tag);
  endtask

  // monitor: quarter period after each rising edge
  initial forever begin
    @(posedge clk);
    #5;
    if (q_exp.size() > 0) begin
      logic [11:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, status_o,  e[11:8], "status");
      check(t, latched_o, e[7:4],  "latched");
      check({t, "/R12"}, rd_data_o, e[3:0], "rd_data");
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    check("R11", status_o, 4'b0001, "reset status");
    check("R11", latched_o, 4'b0000, "reset latched");
    @(negedge clk); rst_ni = 1'b1;
    // oos, err, cnt, mode, loc, glob, done, wr, sel, wd
    step(1,0,0,0,0,0,0,0,0,4'h0, "R11");
    step(1,0,0,0,0,0,0,0,1,4'h0, "R11");
    // sync acquired: live follows, sticky bit0 next edge
    step(0,0,0,0,0,0,0,0,0,4'h0, "R5");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R9");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R9");
    // writes that must not clear
    step(0,0,0,0,0,0,0,1,1,4'hE, "R10");
    step(0,0,0,0,0,0,0,1,0,4'hF, "R10");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R10");
    step(0,0,0,0,0,0,0,1,1,4'h1, "R10");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R10");
    // bit error strobe
    step(0,1,0,0,0,0,0,0,1,4'h0, "R7");
    step(0,0,0,0,0,0,0,0,0,4'h0, "R1");
    // set wins over clear on same edge
    step(0,1,0,0,0,0,0,1,1,4'h4, "R10");
    step(0,0,0,0,0,0,0,1,1,4'h4, "R10");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R10");
    // nonzero count
    step(0,0,1,0,0,0,0,0,0,4'h0, "R4");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R8");
    step(0,0,0,0,0,0,0,0,1,4'h0, "R8");
    step(0,0,0,0,0,0,0,1,1,4'h2, "R10");
    // local handshake, rising request clears nz even with cnt high
    step(0,0,1,0,1,0,0,0,0,4'h0, "R4");
    step(0,0,0,0,1,0,0,0,0,4'h0, "R4");
    step(0,0,0,0,1,0,1,0,0,4'h0, "R2");
    step(0,0,0,0,1,0,0,0,1,4'h0, "R6");
    step(0,0,0,0,1,0,0,0,1,4'h0, "R6");
    step(0,0,0,0,0,0,0,0,0,4'h0, "R3");
    step(0,0,0,0,0,0,0,1,1,4'hF, "R10");
    // global mode: local request ignored
    step(0,0,0,1,1,0,0,0,0,4'h0, "R3");
    step(0,0,0,1,1,0,1,0,0,4'h0, "R3");
    step(0,0,0,1,1,0,0,0,1,4'h0, "R3");
    step(0,0,0,1,0,1,0,0,0,4'h0, "R2");
    step(0,0,0,1,0,1,1,0,0,4'h0, "R2");
    step(0,0,0,1,0,1,0,0,1,4'h0, "R6");
    step(0,0,0,1,0,1,0,0,1,4'h0, "R6");
    // mode switch drops the active request
    step(0,0,0,0,0,1,0,0,0,4'h0, "R3");
    step(0,0,0,0,0,1,0,1,1,4'h8, "R10");
    // lose sync again: change in the other direction
    step(1,0,0,0,0,0,0,0,0,4'h0, "R5");
    step(1,0,0,0,0,0,0,0,1,4'h0, "R9");
    step(1,0,0,0,0,0,0,0,1,4'h0, "R9");
    step(1,0,0,0,0,0,0,0,1,4'h0, "R9");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule